// File: doc/BRIEF.md
# Relative Branch and Loop Unit

This block resolves the relative-branch group of an 8-bit processor. For one instruction it works out whether the branch is taken, the next program counter and the new value of the loop counter register B. It also reports how many clock cycles the instruction costs. It covers three kinds of branch. The unconditional relative jump always branches. Four conditional relative jumps test the zero or carry flag. A loop instruction decrements B and branches while B has not reached zero.

The surrounding decoder presents the opcode byte, the signed displacement byte, the current program counter, the zero and carry flags and register B, and qualifies them with a one-cycle `valid` strobe. The incoming program counter is the address of the displacement byte. The results are registered and appear on the clock edge that samples `valid`. At that point `out_valid` is high for one cycle. An opcode outside the branch group is reported with `hit` low and has no effect.

The control is a two-state machine. `S_IDLE` means no result is pending. `S_DONE` means a result was captured on the last edge. The transition `T_ACCEPT` (any state to `S_DONE`) happens when `valid` is high. The transition `T_RETIRE` (`S_DONE` to `S_IDLE`) happens when `valid` is low. `T_WAIT` keeps `S_IDLE` while `valid` stays low.

Top module: `rbl_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a clock edge on which `valid` was high, and low otherwise. Results are captured on that same edge.
- R2: Opcode 0x18 is always taken and reports 12 cycles.
- R3: Opcodes 0x20, 0x28, 0x30 and 0x38 branch when, respectively, Z=0, Z=1, C=0 and C=1.
- R4: A conditional jump reports 7 cycles when not taken and 12 cycles when taken.
- R5: Opcode 0x10 sets `b_out` to `b_in`-1 modulo 256, so 0x00 becomes 0xFF. It is taken exactly when that new value is nonzero, and reports 13 cycles when taken and 8 when not.
- R6: For a branch opcode that is not taken, `next_pc` = `pc_in`+1 modulo 2^16.
- R7: For a taken branch, `next_pc` = `pc_in`+1+sign-extended `disp`, modulo 2^16.
- R8: Any other opcode gives `hit`=0, `taken`=0, `cycles`=0, `next_pc`=`pc_in` and `b_out`=`b_in`.
- R9: For opcodes 0x18 and 0x20/0x28/0x30/0x38, `b_out` equals `b_in`. The flags never influence 0x10 or 0x18.
- R10: After reset, `out_valid`, `hit`, `taken`, `cycles`, `next_pc` and `b_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Qualifies the instruction inputs for one cycle |
| opcode | input | 8 | Instruction opcode byte |
| disp | input | 8 | Signed two's-complement displacement |
| pc_in | input | 16 | Address of the displacement byte |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| b_in | input | 8 | Current loop counter B |
| out_valid | output | 1 | Result strobe |
| hit | output | 1 | Opcode belongs to the branch group |
| taken | output | 1 | Branch taken |
| cycles | output | 4 | Clock-cycle cost of the instruction |
| next_pc | output | 16 | Program counter after the instruction |
| b_out | output | 8 | Updated loop counter |

## Verification
The loop instruction has two edges that are hard to reach: B=0x01 falls through and B=0x00 wraps to 0xFF and is taken. Program-counter wrap-around needs a negative displacement near address 0x0000 or a positive one near 0xFFFF. The bench sweeps every value of B through the loop opcode. It runs all 256 opcodes under all four flag combinations with displacements and addresses chosen at both ends of the range. Every expected value is computed arithmetically in the bench.

// File: rtl/rbl_pkg.sv
package rbl_pkg;
    localparam logic [7:0] OP_LOOP     = 8'h10;
    localparam logic [7:0] OP_JUMP     = 8'h18;
    localparam logic [7:0] OP_CC_BASE  = 8'h20;
    localparam int         CC_STRIDE   = 8;
    localparam int         NUM_CC      = 4;

    localparam int CYC_CC_SKIP   = 7;
    localparam int CYC_CC_TAKE   = 12;
    localparam int CYC_JUMP      = 12;
    localparam int CYC_LOOP_EXIT = 8;
    localparam int CYC_LOOP_TAKE = 13;

    typedef enum logic [1:0] {
        K_NONE,
        K_JUMP,
        K_COND,
        K_LOOP
    } kind_t;

    // Order is behaviour: the index comes from the opcode's bits 4:3.
    typedef enum logic [1:0] {
        C_NOT_ZERO,
        C_ZERO,
        C_NO_CARRY,
        C_CARRY
    } cond_t;

    typedef enum logic {
        S_IDLE,
        S_DONE
    } state_t;

    typedef struct packed {
        kind_t kind;
        cond_t cond;
    } dec_t;
endpackage

// File: rtl/rbl_decode.sv
module rbl_decode
    import rbl_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic [OP_W-1:0] opcode,
    output dec_t            dec
);
    localparam int IDX_W = $clog2(NUM_CC);

    logic [NUM_CC-1:0] cc_match;

    for (genvar i = 0; i < NUM_CC; i++) begin : g_cc
        localparam logic [OP_W-1:0] CODE = OP_W'(int'(OP_CC_BASE) + i * CC_STRIDE);
        assign cc_match[i] = (opcode == CODE);
    end

    logic [IDX_W-1:0] cc_idx;

    always_comb begin
        cc_idx = '0;
        for (int i = 0; i < NUM_CC; i++) begin
            if (cc_match[i]) begin
                cc_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        dec.cond = cond_t'(cc_idx);
        if (opcode == OP_W'(OP_LOOP)) begin
            dec.kind = K_LOOP;
        end else if (opcode == OP_W'(OP_JUMP)) begin
            dec.kind = K_JUMP;
        end else if (|cc_match) begin
            dec.kind = K_COND;
        end else begin
            dec.kind = K_NONE;
        end
    end
endmodule

// File: rtl/rbl_resolve.sv
module rbl_resolve
    import rbl_pkg::*;
#(
    parameter int CYC_W = 4
) (
    input  dec_t             dec,
    input  logic             flag_z,
    input  logic             flag_c,
    input  logic             cnt_zero,
    output logic             hit,
    output logic             taken,
    output logic [CYC_W-1:0] cycles
);
    logic cond_true;

    always_comb begin
        unique case (dec.cond)
            C_NOT_ZERO: cond_true = !flag_z;
            C_ZERO:     cond_true = flag_z;
            C_NO_CARRY: cond_true = !flag_c;
            C_CARRY:    cond_true = flag_c;
        endcase
    end

    always_comb begin
        hit    = 1'b1;
        taken  = 1'b0;
        cycles = '0;
        unique case (dec.kind)
            K_JUMP: begin
                taken  = 1'b1;
                cycles = CYC_W'(CYC_JUMP);
            end
            K_COND: begin
                taken  = cond_true;
                cycles = cond_true ? CYC_W'(CYC_CC_TAKE) : CYC_W'(CYC_CC_SKIP);
            end
            K_LOOP: begin
                taken  = !cnt_zero;
                cycles = cnt_zero ? CYC_W'(CYC_LOOP_EXIT) : CYC_W'(CYC_LOOP_TAKE);
            end
            K_NONE: begin
                hit = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/rbl_target.sv
module rbl_target #(
    parameter int PC_W   = 16,
    parameter int DISP_W = 8
) (
    input  logic [PC_W-1:0]   pc_in,
    input  logic [DISP_W-1:0] disp,
    input  logic              hit,
    input  logic              taken,
    output logic [PC_W-1:0]   next_pc
);
    localparam int EXT_W = PC_W - DISP_W;

    logic [PC_W-1:0] step_pc;
    logic [PC_W-1:0] disp_ext;

    assign step_pc  = pc_in + PC_W'(1);
    assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};

    always_comb begin
        if (!hit) begin
            next_pc = pc_in;
        end else if (taken) begin
            next_pc = step_pc + disp_ext;
        end else begin
            next_pc = step_pc;
        end
    end
endmodule

// File: rtl/rbl_unit.sv
module rbl_unit
    import rbl_pkg::*;
#(
    parameter int OP_W   = 8,
    parameter int DISP_W = 8,
    parameter int PC_W   = 16,
    parameter int CNT_W  = 8,
    parameter int CYC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [OP_W-1:0]   opcode,
    input  logic [DISP_W-1:0] disp,
    input  logic [PC_W-1:0]   pc_in,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic [CNT_W-1:0]  b_in,
    output logic              out_valid,
    output logic              hit,
    output logic              taken,
    output logic [CYC_W-1:0]  cycles,
    output logic [PC_W-1:0]   next_pc,
    output logic [CNT_W-1:0]  b_out
);
    state_t state_q, state_d;

    dec_t             dec;
    logic [CNT_W-1:0] cnt_dec;
    logic [CNT_W-1:0] cnt_new;
    logic             hit_c, taken_c;
    logic [CYC_W-1:0] cycles_c;
    logic [PC_W-1:0]  next_pc_c;

    rbl_decode #(.OP_W(OP_W)) u_decode (
        .opcode (opcode),
        .dec    (dec)
    );

    assign cnt_dec = b_in - CNT_W'(1);
    assign cnt_new = (dec.kind == K_LOOP) ? cnt_dec : b_in;

    rbl_resolve #(.CYC_W(CYC_W)) u_resolve (
        .dec      (dec),
        .flag_z   (flag_z),
        .flag_c   (flag_c),
        .cnt_zero (cnt_dec == '0),
        .hit      (hit_c),
        .taken    (taken_c),
        .cycles   (cycles_c)
    );

    rbl_target #(.PC_W(PC_W), .DISP_W(DISP_W)) u_target (
        .pc_in   (pc_in),
        .disp    (disp),
        .hit     (hit_c),
        .taken   (taken_c),
        .next_pc (next_pc_c)
    );

    // Next-state logic: T_ACCEPT, T_RETIRE, T_WAIT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: state_d = valid ? S_DONE : S_IDLE;
            S_DONE: state_d = valid ? S_DONE : S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit     <= 1'b0;
            taken   <= 1'b0;
            cycles  <= '0;
            next_pc <= '0;
            b_out   <= '0;
        end else if (valid) begin
            hit     <= hit_c;
            taken   <= taken_c;
            cycles  <= cycles_c;
            next_pc <= next_pc_c;
            b_out   <= cnt_new;
        end
    end

    assign out_valid = (state_q == S_DONE);
endmodule

// File: rtl/rbl_unit_chk.sv
module rbl_unit_chk #(
    parameter int OP_W   = 8,
    parameter int DISP_W = 8,
    parameter int PC_W   = 16,
    parameter int CNT_W  = 8,
    parameter int CYC_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid,
    input logic [OP_W-1:0]   opcode,
    input logic [PC_W-1:0]   pc_in,
    input logic              flag_z,
    input logic              flag_c,
    input logic [CNT_W-1:0]  b_in,
    input logic              out_valid,
    input logic              hit,
    input logic              taken,
    input logic [CYC_W-1:0]  cycles,
    input logic [PC_W-1:0]   next_pc,
    input logic [CNT_W-1:0]  b_out
);
    p_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> out_valid);
    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> !out_valid);
    p_jump_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(opcode) == 8'h18 |-> taken && cycles == 4'd12);
    p_cc_cost_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(opcode[7:5]) == 3'b001 && $past(opcode[2:0]) == 3'b000
        |-> cycles == (taken ? 4'd12 : 4'd7));
    p_loop_cnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(opcode) == 8'h10
        |-> b_out == $past(b_in) - 8'd1 && taken == (b_out != 8'd0));
    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && hit && !taken |-> next_pc == $past(pc_in) + 16'd1);
    p_other_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !hit |-> !taken && cycles == '0 && next_pc == $past(pc_in));
    p_keep_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(opcode) != 8'h10 |-> b_out == $past(b_in));
    p_reset_r10: assert property (@(posedge clk)
        !$past(rst_n) |-> !out_valid && !taken && cycles == '0);
endmodule

bind rbl_unit rbl_unit_chk #(
    .OP_W(OP_W), .DISP_W(DISP_W), .PC_W(PC_W), .CNT_W(CNT_W), .CYC_W(CYC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .valid(valid), .opcode(opcode), .pc_in(pc_in),
    .flag_z(flag_z), .flag_c(flag_c), .b_in(b_in), .out_valid(out_valid),
    .hit(hit), .taken(taken), .cycles(cycles), .next_pc(next_pc), .b_out(b_out)
);

// File: tb/rbl_unit_tb.sv
module rbl_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [7:0]  opcode = '0;
    logic [7:0]  disp = '0;
    logic [15:0] pc_in = '0;
    logic        flag_z = 1'b0;
    logic        flag_c = 1'b0;
    logic [7:0]  b_in = '0;
    logic        out_valid, hit, taken;
    logic [3:0]  cycles;
    logic [15:0] next_pc;
    logic [7:0]  b_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rbl_unit dut_i (
        .clk(clk), .rst_n(rst_n), .valid(valid), .opcode(opcode), .disp(disp),
        .pc_in(pc_in), .flag_z(flag_z), .flag_c(flag_c), .b_in(b_in),
        .out_valid(out_valid), .hit(hit), .taken(taken), .cycles(cycles),
        .next_pc(next_pc), .b_out(b_out)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive one instruction at a falling edge and check its results at the next one.
    task automatic run_one(input logic [7:0] op, input logic [7:0] d, input logic [15:0] pc,
                           input logic z, input logic c, input logic [7:0] b);
        logic        e_hit, e_tk;
        int          e_cy;
        logic [15:0] e_pc;
        logic [7:0]  e_b;
        string       tag, pctag;
        e_hit = 1'b1; e_tk = 1'b0; e_cy = 0; e_b = b; tag = "R8";
        if (op == 8'h18) begin
            e_tk = 1'b1; e_cy = 12; tag = "R2";
        end else if (op == 8'h20 || op == 8'h28 || op == 8'h30 || op == 8'h38) begin
            case (op[4:3])
                2'd0: e_tk = !z;
                2'd1: e_tk = z;
                2'd2: e_tk = !c;
                default: e_tk = c;
            endcase
            e_cy = e_tk ? 12 : 7; tag = "R3";
        end else if (op == 8'h10) begin
            e_b = b - 8'd1; e_tk = (e_b != 0); e_cy = e_tk ? 13 : 8; tag = "R5";
        end else begin
            e_hit = 1'b0;
        end
        if (!e_hit) begin
            e_pc = pc; pctag = "R8";
        end else if (e_tk) begin
            e_pc = pc + 16'd1 + {{8{d[7]}}, d}; pctag = "R7";
        end else begin
            e_pc = pc + 16'd1; pctag = "R6";
        end
        opcode = op; disp = d; pc_in = pc; flag_z = z; flag_c = c; b_in = b; valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        valid = 1'b0;
        check("R1", "out_valid", int'(out_valid), 1);
        check(tag, "hit", int'(hit), int'(e_hit));
        check(tag, "taken", int'(taken), int'(e_tk));
        check((tag == "R3") ? "R4" : tag, "cycles", int'(cycles), e_cy);
        check(pctag, "next_pc", int'(next_pc), int'(e_pc));
        check((tag == "R5") ? "R5" : "R9", "b_out", int'(b_out), int'(e_b));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", "out_valid", int'(out_valid), 0);
        check("R10", "taken", int'(taken), 0);
        check("R10", "cycles", int'(cycles), 0);
        check("R10", "next_pc", int'(next_pc), 0);
        check("R10", "b_out", int'(b_out), 0);
        check("R10", "hit", int'(hit), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle out_valid", int'(out_valid), 0);

        // All opcodes, all flag combinations, alternating displacement signs and wrap addresses
        for (int op = 0; op < 256; op++) begin
            for (int f = 0; f < 4; f++) begin
                logic [7:0]  d;
                logic [15:0] pc;
                d  = (f[0]) ? 8'h80 : 8'h7F;
                pc = (f[0]) ? 16'h0005 : 16'hFFF0;
                run_one(8'(op), d, pc, f[1], f[0], 8'(op + f));
            end
        end

        // R5: every B value through the loop opcode, flags varied (R9: flags ignored)
        for (int b = 0; b < 256; b++) begin
            run_one(8'h10, 8'(b * 3), 16'(b * 257), b[0], b[1], 8'(b));
        end

        // R6/R7: wrap corners
        run_one(8'h18, 8'h00, 16'hFFFF, 1'b0, 1'b0, 8'h11);
        run_one(8'h18, 8'hFE, 16'h0000, 1'b1, 1'b1, 8'h22);
        run_one(8'h20, 8'hF0, 16'h0003, 1'b1, 1'b0, 8'h33);
        run_one(8'h38, 8'h10, 16'hFFF5, 1'b0, 1'b1, 8'h44);

        // R1: strobe drops when valid is low
        @(negedge clk);
        check("R1", "out_valid after idle", int'(out_valid), 0);
        check("R1", "held taken", int'(taken), 1);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
            wait (done);
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule